// File: doc/BRIEF.md
# Hashed Page Table Group Scanner

This block walks one hash group of a page table in memory, looking for the entry that maps a given page. A caller supplies the group base address, which hash function produced it (primary or secondary), a compare tag, the access kind and the protection key. The scanner then fetches the entries one at a time over a single-outstanding read port. Each entry is tested for a valid mark, the expected hash-select value and a tag match, and a matching entry is then tested for access rights.

The first entry that matches and grants the access ends the walk. A matching entry that refuses the access is remembered, and the walk goes on in case a later entry grants it. Two matching entries that disagree about the physical page are treated as a corrupt table: the walk stops at once and reports a miss. For the selected entry the scanner sets the referenced flag, and the changed flag on a granted store. It writes the entry's second word back only if those flags actually changed. Entries are either two 32-bit words (narrow mode) or two 64-bit words (wide mode).

The controller states are IDLE (waiting for `start`), RD0 (request the first word), W0 (wait for it), RD1 (request the second word), W1 (wait for it), EVAL (classify the entry), FLAGS (compute the flag update), WRITE (write-back until acknowledged) and DONE (one-cycle completion). The transitions are:
- IDLE→RD0 on `start`.
- RD0→W0.
- W0→RD1 on `rd_valid`.
- RD1→W1.
- W1→EVAL on `rd_valid`.
- EVAL→RD0 to go to the next entry.
- EVAL→FLAGS on a grant, or at the end of the group when a violation is held.
- EVAL→DONE on a conflict, or on a miss at the end of the group.
- FLAGS→WRITE when the word was altered, and FLAGS→DONE when it was not.
- WRITE→DONE on `wr_ack`.
- DONE→IDLE.

Top module: `hpt_group_scanner`

## Requirements
- R1: Entry i of the group has its first word at `base_addr + i*S` and its second word at `base_addr + i*S + S/2`. S is 8 in narrow mode and 16 in wide mode. Entries are read in increasing index order, first word before second word.
- R2: In narrow mode only `rd_data[31:0]` is used. The valid mark is bit 31 and the hash-select bit is bit 6 of the first word. The tag is the remaining bits of that word, compared with `cmp_tag[31:0]` at the same positions.
- R3: In wide mode the valid mark is bit 0 and the hash-select bit is bit 1 of the first word. The tag is bits 63:2, compared with `cmp_tag[63:2]`. An entry matches only when it is valid, its hash-select bit equals `hash_sel` and its tag matches.
- R4: Rights come from bits 1:0 of the second word (pp). With `key`=0, pp 0, 1 and 2 allow reads and writes, and pp 3 allows reads only. With `key`=1, pp 0 allows nothing, pp 1 and 3 allow reads only, and pp 2 allows reads and writes.
- R5: A matching entry that grants the access ends the walk with no further reads. The result is 2'b01 (granted) and `sel_idx` is its index.
- R6: A matching entry that refuses the access is recorded and the walk continues. If no entry grants, the result after the last entry is 2'b10 (violation), with `sel_idx` set to the last refusing index.
- R7: Conflict: a match found while a refusal is recorded whose second word, ignoring bits 8, 7, 1 and 0, differs from the recorded one. It ends the walk at once with result 2'b00 (miss) and no write-back.
- R8: With no match among the 8 entries the result is 2'b00 (miss) and nothing is written.
- R9: For the selected entry, bit 8 (referenced) of the second word is set on any access. Bit 7 (changed) is set only on a granted write. No other bit is altered.
- R10: The second word is written back to its own address only if the update altered it. `wr_req` and its address and data are held until `wr_ack`. In narrow mode the upper 32 bits of `wr_data` are zero.
- R11: `busy` rises the cycle after an accepted `start` and stays high until the cycle `done` pulses. `done` is high for exactly one cycle, together with `result` and `sel_idx`.
- R12: `rd_req` is a one-cycle pulse, and a new read is requested only after `rd_valid` has returned the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| base_addr | input | ADDR_W | Byte address of the hash group |
| wide_mode | input | 1 | 1: 64-bit words, 0: 32-bit words |
| hash_sel | input | 1 | Expected hash-select bit value |
| cmp_tag | input | 64 | Tag compared against the first word |
| is_write | input | 1 | Access is a store |
| key | input | 1 | Protection key |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 miss, 01 granted, 10 violation |
| sel_idx | output | 3 | Selected entry index (0 on miss) |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | ADDR_W | Read byte address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 64 | Read data |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 64 | Write data |
| wr_ack | input | 1 | Write accepted |

## Verification
The bench builds groups in which a granted entry sits behind invalid, wrong-hash and wrong-tag entries. A scanner that ignored any of those checks would stop too early or at the wrong index.

It places refusals before grants, refusals alone, and a refusal followed by a conflicting match. A design that stopped on the first refusal, forgot it, or let a conflict through would be caught by the read count and result code.

Entries whose referenced and changed flags are already set show whether a write-back is skipped when nothing changed. Narrow-mode reads return junk in the upper half, which exposes a design that fails to mask it.

// File: rtl/hpt_scan_pkg.sv
package hpt_scan_pkg;

    typedef enum logic [1:0] {
        RES_MISS  = 2'b00,
        RES_GRANT = 2'b01,
        RES_VIOL  = 2'b10
    } scan_res_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD0,
        S_W0,
        S_RD1,
        S_W1,
        S_EVAL,
        S_FLAGS,
        S_WRITE,
        S_DONE
    } scan_state_e;

    localparam int REF_BIT = 8;
    localparam int CHG_BIT = 7;
    localparam int WORD_W  = 64;

    localparam logic [WORD_W-1:0] FLAG_MASK = (WORD_W'(1) << REF_BIT) | (WORD_W'(1) << CHG_BIT);
    localparam logic [WORD_W-1:0] PAGE_MASK = ~(FLAG_MASK | WORD_W'(3));

endpackage

// File: rtl/hpt_entry_check.sv
module hpt_entry_check
    import hpt_scan_pkg::*;
(
    input  logic              wide,
    input  logic              hsel,
    input  logic [WORD_W-1:0] tag,
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic              is_write,
    input  logic              key,
    output logic              hit,
    output logic              allowed
);

    localparam logic [31:0] NARROW_TAG_MASK = 32'h7FFF_FFBF;

    logic       valid_bit;
    logic       hsel_bit;
    logic       tag_ok;
    logic [1:0] pp;
    logic       can_rd;
    logic       can_wr;

    always_comb begin
        if (wide) begin
            valid_bit = w0[0];
            hsel_bit  = w0[1];
            tag_ok    = (w0[WORD_W-1:2] == tag[WORD_W-1:2]);
        end else begin
            valid_bit = w0[31];
            hsel_bit  = w0[6];
            tag_ok    = ((w0[31:0] & NARROW_TAG_MASK) == (tag[31:0] & NARROW_TAG_MASK));
        end
        hit = valid_bit && (hsel_bit == hsel) && tag_ok;
    end

    always_comb begin
        pp = w1[1:0];
        if (!key) begin
            can_rd = 1'b1;
            can_wr = (pp != 2'd3);
        end else begin
            can_rd = (pp != 2'd0);
            can_wr = (pp == 2'd2);
        end
        allowed = is_write ? can_wr : can_rd;
    end

endmodule

// File: rtl/hpt_flag_update.sv
module hpt_flag_update
    import hpt_scan_pkg::*;
(
    input  logic [WORD_W-1:0] w1_in,
    input  logic              set_chg,
    output logic [WORD_W-1:0] w1_out,
    output logic              altered
);

    always_comb begin
        w1_out = w1_in;
        w1_out[REF_BIT] = 1'b1;
        if (set_chg) begin
            w1_out[CHG_BIT] = 1'b1;
        end
        altered = (w1_out != w1_in);
    end

    // R9
    always_comb begin
        only_flags_chk: assert (((w1_in ^ w1_out) & ~FLAG_MASK) == '0);
    end

endmodule

// File: rtl/hpt_group_scanner.sv
module hpt_group_scanner
    import hpt_scan_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_ENT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              wide_mode,
    input  logic              hash_sel,
    input  logic [63:0]       cmp_tag,
    input  logic              is_write,
    input  logic              key,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [2:0]        sel_idx,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [63:0]       rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [63:0]       wr_data,
    input  logic              wr_ack
);

    localparam int IDX_W     = $clog2(NUM_ENT);
    localparam int NAR_SHIFT = 3;
    localparam int WID_SHIFT = 4;

    scan_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic              wide_q, hsel_q, wr_q, key_q;
    logic [WORD_W-1:0] tag_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] w0_q, w1_q;
    logic              viol_seen_q;
    logic [IDX_W-1:0]  viol_idx_q;
    logic [WORD_W-1:0] viol_w1_q;
    logic [WORD_W-1:0] sel_w1_q;
    logic [IDX_W-1:0]  sel_idx_q;
    scan_res_e         res_q;
    logic [WORD_W-1:0] wdata_q;

    logic              hit, allowed;
    logic              conflict;
    logic              last_ent;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] upd_w1;
    logic              upd_altered;
    logic [ADDR_W-1:0] ent_off;
    logic [ADDR_W-1:0] half_off;

    hpt_entry_check u_check (
        .wide     (wide_q),
        .hsel     (hsel_q),
        .tag      (tag_q),
        .w0       (w0_q),
        .w1       (w1_q),
        .is_write (wr_q),
        .key      (key_q),
        .hit      (hit),
        .allowed  (allowed)
    );

    hpt_flag_update u_flags (
        .w1_in   (sel_w1_q),
        .set_chg (wr_q && (res_q == RES_GRANT)),
        .w1_out  (upd_w1),
        .altered (upd_altered)
    );

    assign rd_word  = wide_mode_word(wide_q, rd_data);
    assign conflict = hit && viol_seen_q && ((w1_q & PAGE_MASK) != (viol_w1_q & PAGE_MASK));
    assign last_ent = (idx_q == IDX_W'(NUM_ENT - 1));
    assign ent_off  = ADDR_W'(idx_q) << (wide_q ? WID_SHIFT : NAR_SHIFT);
    assign half_off = wide_q ? ADDR_W'(8) : ADDR_W'(4);

    function automatic logic [WORD_W-1:0] wide_mode_word(input logic wide, input logic [63:0] d);
        return wide ? d : {32'h0, d[31:0]};
    endfunction

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_RD0;
            S_RD0:   state_d = S_W0;
            S_W0:    if (rd_valid) state_d = S_RD1;
            S_RD1:   state_d = S_W1;
            S_W1:    if (rd_valid) state_d = S_EVAL;
            S_EVAL: begin
                if (conflict) begin
                    state_d = S_DONE;
                end else if (hit && allowed) begin
                    state_d = S_FLAGS;
                end else if (!last_ent) begin
                    state_d = S_RD0;
                end else if (viol_seen_q || hit) begin
                    state_d = S_FLAGS;
                end else begin
                    state_d = S_DONE;
                end
            end
            S_FLAGS: state_d = upd_altered ? S_WRITE : S_DONE;
            S_WRITE: if (wr_ack) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            wide_q      <= 1'b0;
            hsel_q      <= 1'b0;
            wr_q        <= 1'b0;
            key_q       <= 1'b0;
            tag_q       <= '0;
            idx_q       <= '0;
            w0_q        <= '0;
            w1_q        <= '0;
            viol_seen_q <= 1'b0;
            viol_idx_q  <= '0;
            viol_w1_q   <= '0;
            sel_w1_q    <= '0;
            sel_idx_q   <= '0;
            res_q       <= RES_MISS;
            wdata_q     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        base_q      <= base_addr;
                        wide_q      <= wide_mode;
                        hsel_q      <= hash_sel;
                        wr_q        <= is_write;
                        key_q       <= key;
                        tag_q       <= cmp_tag;
                        idx_q       <= '0;
                        viol_seen_q <= 1'b0;
                        sel_idx_q   <= '0;
                        res_q       <= RES_MISS;
                    end
                end
                S_W0: if (rd_valid) w0_q <= rd_word;
                S_W1: if (rd_valid) w1_q <= rd_word;
                S_EVAL: begin
                    if (conflict) begin
                        res_q     <= RES_MISS;
                        sel_idx_q <= '0;
                    end else if (hit && allowed) begin
                        res_q     <= RES_GRANT;
                        sel_idx_q <= idx_q;
                        sel_w1_q  <= w1_q;
                    end else begin
                        if (hit) begin
                            viol_seen_q <= 1'b1;
                            viol_idx_q  <= idx_q;
                            viol_w1_q   <= w1_q;
                        end
                        if (!last_ent) begin
                            idx_q <= idx_q + 1'b1;
                        end else if (hit) begin
                            res_q     <= RES_VIOL;
                            sel_idx_q <= idx_q;
                            sel_w1_q  <= w1_q;
                        end else if (viol_seen_q) begin
                            res_q     <= RES_VIOL;
                            sel_idx_q <= viol_idx_q;
                            sel_w1_q  <= viol_w1_q;
                        end else begin
                            res_q     <= RES_MISS;
                            sel_idx_q <= '0;
                        end
                    end
                end
                S_FLAGS: wdata_q <= upd_w1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != S_IDLE) && (state_q != S_DONE);
        done    = (state_q == S_DONE);
        result  = res_q;
        sel_idx = 3'(sel_idx_q);
        rd_req  = (state_q == S_RD0) || (state_q == S_RD1);
        rd_addr = base_q + ent_off + ((state_q == S_RD1) ? half_off : '0);
        wr_req  = (state_q == S_WRITE);
        wr_addr = base_q + (ADDR_W'(sel_idx_q) << (wide_q ? WID_SHIFT : NAR_SHIFT)) + half_off;
        wr_data = wdata_q;
    end

    // R12
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    // R8
    miss_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'b00) |-> $past(!wr_req));

endmodule

// File: tb/test_hpt_group_scanner.sv
module test_hpt_group_scanner;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          wide_mode = 1'b0;
    logic          hash_sel = 1'b0;
    logic [63:0]   cmp_tag = '0;
    logic          is_write = 1'b0;
    logic          key = 1'b0;
    logic          busy, done;
    logic [1:0]    result;
    logic [2:0]    sel_idx;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [63:0]   rd_data = '0;
    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [63:0]   wr_data;
    logic          wr_ack = 1'b0;

    always #5 clk = ~clk;

    hpt_group_scanner #(.ADDR_W(AW), .NUM_ENT(8)) i_hpt_group_scanner (
        .clk, .rst_n, .start, .base_addr, .wide_mode, .hash_sel, .cmp_tag,
        .is_write, .key, .busy, .done, .result, .sel_idx, .rd_req, .rd_addr,
        .rd_valid, .rd_data, .wr_req, .wr_addr, .wr_data, .wr_ack
    );

    localparam logic [31:0] TAG32 = 32'h0ABC_DE25;
    localparam logic [63:0] TAG64 = 64'h0123_4567_89AB_CDE0;
    localparam logic [63:0] PG32  = 64'h0000_0000_1234_5000;
    localparam logic [63:0] PG64  = 64'h0000_00AB_CDEF_3000;

    // {wide, wr, key, hsel, codes[8x4], res[2], idx[3], entries read[4], write expected}
    localparam int NV = 16;
    localparam logic [45:0] VEC [NV] = '{
        {1'b0,1'b0,1'b1,1'b0,32'h0000_0104,2'b01,3'd2,4'd3,1'b1},
        {1'b0,1'b1,1'b1,1'b0,32'h0000_0001,2'b01,3'd0,4'd1,1'b1},
        {1'b0,1'b1,1'b1,1'b0,32'h0000_0002,2'b10,3'd0,4'd8,1'b1},
        {1'b0,1'b1,1'b1,1'b0,32'h0000_0102,2'b01,3'd2,4'd3,1'b1},
        {1'b0,1'b0,1'b1,1'b0,32'h3000_0003,2'b10,3'd7,4'd8,1'b1},
        {1'b0,1'b1,1'b1,1'b0,32'h0000_0602,2'b00,3'd0,4'd3,1'b0},
        {1'b0,1'b0,1'b1,1'b0,32'h0000_0000,2'b00,3'd0,4'd8,1'b0},
        {1'b0,1'b0,1'b1,1'b0,32'h0000_0045,2'b00,3'd0,4'd8,1'b0},
        {1'b0,1'b0,1'b1,1'b0,32'h0000_0007,2'b01,3'd0,4'd1,1'b0},
        {1'b0,1'b1,1'b1,1'b0,32'h0000_0008,2'b01,3'd0,4'd1,1'b0},
        {1'b0,1'b1,1'b1,1'b0,32'h0000_0007,2'b01,3'd0,4'd1,1'b1},
        {1'b1,1'b0,1'b1,1'b0,32'h0010_0000,2'b01,3'd5,4'd6,1'b1},
        {1'b1,1'b1,1'b1,1'b0,32'h0000_0242,2'b10,3'd2,4'd8,1'b1},
        {1'b1,1'b1,1'b0,1'b0,32'h0000_0003,2'b01,3'd0,4'd1,1'b1},
        {1'b0,1'b0,1'b0,1'b1,32'h0000_0015,2'b01,3'd1,4'd2,1'b1},
        {1'b1,1'b1,1'b1,1'b1,32'h0000_0063,2'b00,3'd0,4'd2,1'b0}
    };

    int n_chk = 0;
    int n_bad = 0;

    // memory image of the current group, built by the bench
    logic [63:0] m_w0 [8];
    logic [63:0] m_w1 [8];
    logic [AW-1:0] cur_base = '0;
    logic          cur_wide = 1'b0;
    int            rd_mark = 0;

    int            rd_cnt = 0;
    int            addr_err = 0;
    int            ovl_err = 0;
    int            wr_cnt = 0;
    logic [AW-1:0] last_waddr = '0;
    logic [63:0]   last_wdata = '0;
    int            lat = 0;
    logic [AW-1:0] raddr = '0;

    function automatic logic [63:0] fetch(input logic [AW-1:0] a);
        int stride, off, ix;
        logic [63:0] d;
        stride = cur_wide ? 16 : 8;
        off = int'(a - cur_base);
        ix = (off / stride) % 8;
        d = ((off % stride) != 0) ? m_w1[ix] : m_w0[ix];
        return cur_wide ? d : {32'hA5A5_A5A5, d[31:0]};
    endfunction

    // memory model: two-cycle read latency, one-cycle write acknowledge
    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                rd_valid <= 1'b1;
                rd_data  <= fetch(raddr);
            end
        end
        if (rd_req) begin
            int k, stride;
            k = rd_cnt - rd_mark;
            stride = cur_wide ? 16 : 8;
            if (rd_addr != cur_base + AW'((k / 2) * stride + (k % 2) * (stride / 2)))
                addr_err <= addr_err + 1;
            if (lat != 0) ovl_err <= ovl_err + 1;
            lat    <= 2;
            raddr  <= rd_addr;
            rd_cnt <= rd_cnt + 1;
        end
        if (wr_req && !wr_ack) begin
            wr_ack     <= 1'b1;
            wr_cnt     <= wr_cnt + 1;
            last_waddr <= wr_addr;
            last_wdata <= wr_data;
        end else begin
            wr_ack <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_w0(input logic [3:0] c, input logic wide, input logic h);
        logic hb;
        logic [63:0] w;
        hb = (c == 4'd5) ? ~h : h;
        if (wide) begin
            w = TAG64 | {62'h0, hb, (c != 4'd0)};
            if (c == 4'd4) w = w ^ 64'h400;
        end else begin
            w = {32'h0, TAG32 | ({31'h0, (c != 4'd0)} << 31) | ({31'h0, hb} << 6)};
            if (c == 4'd4) w = w ^ 64'h400;
        end
        return w;
    endfunction

    function automatic logic [63:0] mk_w1(input logic [3:0] c, input logic wide);
        logic [63:0] pg;
        logic [1:0]  pp;
        logic [63:0] w;
        pg = wide ? PG64 : PG32;
        if (c == 4'd6) pg = pg + 64'h1000;
        unique case (c)
            4'd2:    pp = 2'd3;
            4'd3:    pp = 2'd0;
            default: pp = 2'd2;
        endcase
        w = pg | {62'h0, pp};
        if (c == 4'd7 || c == 4'd8) w[8] = 1'b1;
        if (c == 4'd8) w[7] = 1'b1;
        return w;
    endfunction

    task automatic run_walk(output bit timed_out);
        int t;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        timed_out = 1'b0;
        while (!done && t < 400) begin
            @(negedge clk);
            t++;
        end
        if (!done) timed_out = 1'b1;
    endtask

    initial begin
        #(2_000_000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R11)
        check("R11 busy at reset", 64'(busy), 64'd0);
        check("R11 done at reset", 64'(done), 64'd0);
        check("R12 rd_req at reset", 64'(rd_req), 64'd0);
        check("R10 wr_req at reset", 64'(wr_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [45:0] e;
            logic        vw, vwr, vk, vh, wexp;
            logic [1:0]  eres;
            logic [2:0]  eidx;
            logic [3:0]  nent;
            int          w_before, stride;
            bit          to;
            logic [63:0] exp_w;
            e    = VEC[v];
            vw   = e[45]; vwr = e[44]; vk = e[43]; vh = e[42];
            eres = e[9:8]; eidx = e[7:5]; nent = e[4:1]; wexp = e[0];
            for (int i = 0; i < 8; i++) begin
                m_w0[i] = mk_w0(e[10 + 4*i +: 4], vw, vh);
                m_w1[i] = mk_w1(e[10 + 4*i +: 4], vw);
            end
            cur_wide  = vw;
            cur_base  = vw ? 32'h0008_0000 : 32'h0004_0000;
            base_addr = cur_base;
            wide_mode = vw;
            hash_sel  = vh;
            is_write  = vwr;
            key       = vk;
            cmp_tag   = vw ? TAG64 : {32'hFFFF_0000, TAG32};
            rd_mark   = rd_cnt;
            w_before  = wr_cnt;
            addr_err  = 0;
            ovl_err   = 0;
            stride    = vw ? 16 : 8;
            run_walk(to);
            if (to) begin
                check("R11 done within bound", 64'd0, 64'd1);
                continue;
            end
            // R5 R6 R7 R8 result code; R4 rights; R2 R3 matching
            check($sformatf("R5 R6 R7 R8 result vec%0d", v), 64'(result), 64'(eres));
            if (eres != 2'b00)
                check($sformatf("R5 R6 sel_idx vec%0d", v), 64'(sel_idx), 64'(eidx));
            // R5 R7 early stop, R6 R8 full walk
            check($sformatf("R5 R7 reads vec%0d", v), 64'(rd_cnt - rd_mark), 64'(2 * nent));
            check($sformatf("R1 read order vec%0d", v), 64'(addr_err), 64'd0);
            check($sformatf("R12 single outstanding vec%0d", v), 64'(ovl_err), 64'd0);
            // R10 conditional write-back
            check($sformatf("R10 write count vec%0d", v), 64'(wr_cnt - w_before), 64'(wexp));
            if (wexp) begin
                exp_w = m_w1[eidx] | 64'h100;
                if (eres == 2'b01 && vwr) exp_w = exp_w | 64'h80;
                check($sformatf("R9 write data vec%0d", v), last_wdata, exp_w);
                check($sformatf("R10 write addr vec%0d", v), 64'(last_waddr),
                      64'(cur_base + AW'(int'(eidx) * stride + stride / 2)));
            end
            @(negedge clk);
            check($sformatf("R11 done one cycle vec%0d", v), 64'(done), 64'd0);
        end

        // R11: busy throughout a walk and cleared by reset mid-walk
        for (int i = 0; i < 8; i++) begin
            m_w0[i] = mk_w0(4'd0, 1'b0, 1'b0);
            m_w1[i] = mk_w1(4'd0, 1'b0);
        end
        cur_wide = 1'b0; cur_base = 32'h0004_0000; base_addr = cur_base;
        wide_mode = 1'b0; rd_mark = rd_cnt;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 busy after start", 64'(busy), 64'd1);
        repeat (5) @(negedge clk);
        check("R11 busy mid walk", 64'(busy), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 busy cleared by reset", 64'(busy), 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule